// File: doc/BRIEF.md
# PC Card 16-bit Access Cycle Sequencer

This block runs memory and I/O cycles on one 16-bit PC Card socket for a host-side request port. The host presents an address, a read or write flag, a memory or I/O flag, an attribute-space flag, a width choice and write data for one clock while the block is idle. The block then drives the socket's active-low strobes, card enables, space select, address and data lines through three timed phases: address setup, strobe active and hold. It returns read data together with a single-clock completion pulse.

The length of each phase comes from three configuration inputs, each counted in clocks. A value of zero counts as one clock. The card can stretch the strobe phase with its wait input. On a 16-bit I/O request the block samples the card's I/O-width input. If the card reports an 8-bit location, the request is carried out as two byte cycles, with the even byte first.

Top module: `pccard_seq`

## Requirements
- R1: Exactly one strobe is low, and only during the active phase. A memory read drives `card_oe_n`, a memory write drives `card_we_n`, an I/O read drives `card_iord_n` and an I/O write drives `card_iowr_n`. `card_d_oe` is high during the setup, active and hold phases of writes only.
- R2: On memory cycles, `card_reg_n` is low when the attribute flag is set and high when it is clear. On I/O cycles, `card_reg_n` is low throughout setup, active and hold. Outside a cycle it is high.
- R3: A 16-bit access drives both `card_ce1_n` and `card_ce2_n` low and drives address bit 0 low. It carries all 16 bits of write data, and a read returns all 16 bits of the card data.
- R4: In 8-bit mode only `card_ce1_n` goes low and address bit 0 follows the request. Write data travels on bits 7:0 as `req_wdata[7:0]` with bits 15:8 driven zero. A read returns the card's bits 7:0 with the upper byte zero.
- R5: The active phase lasts for the configured active length. It is extended while `card_wait_n` is low at the phase's last counted clock. With the card holding wait low for W clocks from the strobe's first clock, the strobe stays low for max(active, W+1) clocks.
- R6: Setup, active and hold each last their configured number of clocks, with zero treated as one. `done` rises in the clock after the last hold clock. Counting the accepting edge as 0, `done` is high in clock setup+active+hold+1 for a single cycle.
- R7: A 16-bit I/O request whose `card_iois16_n` is high at the end of setup runs as two 8-bit cycles. Only CE1 is low in each. The first cycle has A0=0 and the low data byte, the second has A0=1 and the high data byte. The read result is {second byte, first byte}, and `done` follows the second hold.
- R8: A 16-bit I/O request whose `card_iois16_n` is low at the end of setup runs as a single 16-bit cycle.
- R9: `done` is high for exactly one clock per request. `rd_data` is captured on the clock edge where the strobe is released. Write requests leave `rd_data` unchanged.
- R10: After reset, all strobes, both card enables and `card_reg_n` are high, `done`, `busy` and `card_d_oe` are low and `rd_data` is zero. A request raised while `busy` is high is ignored and does not start a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | Socket address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_attr | input | 1 | 1 = attribute memory (memory cycles only) |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| req_wdata | input | DATA_W | Write data |
| cfg_setup | input | CNT_W | Setup length in clocks (0 acts as 1) |
| cfg_active | input | CNT_W | Minimum strobe length in clocks (0 acts as 1) |
| cfg_hold | input | CNT_W | Hold length in clocks (0 acts as 1) |
| card_wait_n | input | 1 | Card wait request, active low |
| card_iois16_n | input | 1 | Card reports 16-bit I/O location, active low |
| card_d_in | input | DATA_W | Data from the card |
| card_a | output | ADDR_W | Socket address |
| card_d_out | output | DATA_W | Data to the card |
| card_d_oe | output | 1 | Data drive enable toward the card |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_ce1_n | output | 1 | Even byte enable |
| card_ce2_n | output | 1 | Odd byte enable |
| card_reg_n | output | 1 | Space select |
| rd_data | output | DATA_W | Last read result |
| done | output | 1 | Completion pulse |
| busy | output | 1 | Cycle in progress |

## Verification
A wrong phase counter shows at once as a strobe that is too short or too long in clocks, and as a `done` pulse on the wrong clock. A stuck wait path shows as a strobe that never releases, which the watchdog catches. A lost split flag shows within one cycle: CE2 stays low on an 8-bit I/O location, only one strobe appears where two are expected, or the high read byte is wrong. A mis-decoded space select or byte lane is visible on the first active clock of the affected cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_HOLD,
        ST_DONE
    } pcc_state_e;
endpackage

// File: rtl/pcc_strobe_dec.sv
module pcc_strobe_dec
    import pcc_pkg::*;
(
    input  pcc_state_e st,
    input  logic       io,
    input  logic       wr,
    input  logic       attr,
    output logic       window,
    output logic       oe_n,
    output logic       we_n,
    output logic       iord_n,
    output logic       iowr_n,
    output logic       reg_n,
    output logic       d_oe
);
    logic strobe_on;

    always_comb begin
        window    = (st == ST_SETUP) || (st == ST_ACTIVE) || (st == ST_HOLD);
        strobe_on = (st == ST_ACTIVE);
        oe_n      = !(strobe_on && !io && !wr);
        we_n      = !(strobe_on && !io &&  wr);
        iord_n    = !(strobe_on &&  io && !wr);
        iowr_n    = !(strobe_on &&  io &&  wr);
        reg_n     = window ? (io ? 1'b0 : !attr) : 1'b1;
        d_oe      = window && wr;
    end
endmodule

// File: rtl/pcc_lane_plan.sv
module pcc_lane_plan #(
    parameter int DATA_W = 16
) (
    input  logic              window,
    input  logic              wide,
    input  logic              split,
    input  logic              piece,
    input  logic              addr0,
    input  logic [DATA_W-1:0] wdata,
    output logic              narrow,
    output logic              ce1_n,
    output logic              ce2_n,
    output logic              a0,
    output logic [DATA_W-1:0] dout
);
    localparam int BYTE_W = DATA_W / 2;

    logic [BYTE_W-1:0] byte_sel;

    always_comb begin
        narrow   = !wide || split;
        byte_sel = (wide && piece) ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];
        ce1_n    = !window;
        ce2_n    = !(window && !narrow);
        if (narrow) begin
            a0   = wide ? piece : addr0;
            dout = {{BYTE_W{1'b0}}, byte_sel};
        end else begin
            a0   = 1'b0;
            dout = wdata;
        end
    end
endmodule

// File: rtl/pccard_seq.sv
module pccard_seq
    import pcc_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_attr,
    input  logic              req_wide,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_active,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              card_wait_n,
    input  logic              card_iois16_n,
    input  logic [DATA_W-1:0] card_d_in,
    output logic [ADDR_W-1:0] card_a,
    output logic [DATA_W-1:0] card_d_out,
    output logic              card_d_oe,
    output logic              card_oe_n,
    output logic              card_we_n,
    output logic              card_iord_n,
    output logic              card_iowr_n,
    output logic              card_ce1_n,
    output logic              card_ce2_n,
    output logic              card_reg_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy
);
    localparam int BYTE_W = DATA_W / 2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        pcc_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              io;
        logic              attr;
        logic              wide;
        logic              split;
        logic              piece;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic window, narrow, a0, strobe_any;

    function automatic logic [CNT_W-1:0] plen(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    pcc_strobe_dec u_dec (
        .st     (q.st),
        .io     (q.io),
        .wr     (q.wr),
        .attr   (q.attr),
        .window (window),
        .oe_n   (card_oe_n),
        .we_n   (card_we_n),
        .iord_n (card_iord_n),
        .iowr_n (card_iowr_n),
        .reg_n  (card_reg_n),
        .d_oe   (card_d_oe)
    );

    pcc_lane_plan #(.DATA_W(DATA_W)) u_lane (
        .window (window),
        .wide   (q.wide),
        .split  (q.split),
        .piece  (q.piece),
        .addr0  (q.addr[0]),
        .wdata  (q.wdata),
        .narrow (narrow),
        .ce1_n  (card_ce1_n),
        .ce2_n  (card_ce2_n),
        .a0     (a0),
        .dout   (card_d_out)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_SETUP;
                    d.cnt   = plen(cfg_setup);
                    d.addr  = req_addr;
                    d.wr    = req_write;
                    d.io    = req_io;
                    d.attr  = req_attr;
                    d.wide  = req_wide;
                    d.wdata = req_wdata;
                    d.split = 1'b0;
                    d.piece = 1'b0;
                end
            end
            ST_SETUP: begin
                if (q.cnt > ONE) begin
                    d.cnt = q.cnt - ONE;
                end else begin
                    d.st  = ST_ACTIVE;
                    d.cnt = plen(cfg_active);
                    if (!q.piece && q.wide && q.io) d.split = card_iois16_n;
                end
            end
            ST_ACTIVE: begin
                if (q.cnt > ONE) begin
                    d.cnt = q.cnt - ONE;
                end else if (card_wait_n) begin
                    d.st  = ST_HOLD;
                    d.cnt = plen(cfg_hold);
                    if (!q.wr) begin
                        if (!narrow)
                            d.rdata = card_d_in;
                        else if (q.split && q.piece)
                            d.rdata[DATA_W-1:BYTE_W] = card_d_in[BYTE_W-1:0];
                        else if (q.split)
                            d.rdata[BYTE_W-1:0] = card_d_in[BYTE_W-1:0];
                        else
                            d.rdata = {{BYTE_W{1'b0}}, card_d_in[BYTE_W-1:0]};
                    end
                end
            end
            ST_HOLD: begin
                if (q.cnt > ONE) begin
                    d.cnt = q.cnt - ONE;
                end else if (q.split && !q.piece) begin
                    d.st    = ST_SETUP;
                    d.cnt   = plen(cfg_setup);
                    d.piece = 1'b1;
                end else begin
                    d.st = ST_DONE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign card_a     = {q.addr[ADDR_W-1:1], a0};
    assign rd_data    = q.rdata;
    assign done       = (q.st == ST_DONE);
    assign busy       = (q.st != ST_IDLE);
    assign strobe_any = !(card_oe_n && card_we_n && card_iord_n && card_iowr_n);

    // R3
    strobe_has_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_any |-> !card_ce1_n);

    // R4
    narrow_no_ce2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.wide && !card_ce1_n) |-> card_ce2_n);

    // R2
    io_reg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.io && !card_ce1_n) |-> !card_reg_n);

    // R5
    wait_keeps_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_any && !card_wait_n) |=> strobe_any);

    // R7
    split_even_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.split && !q.piece && strobe_any) |-> (!card_a[0] && card_ce2_n));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (card_ce1_n && card_ce2_n && card_reg_n && !strobe_any));
endmodule

// File: tb/sim_pccard_seq.sv
module sim_pccard_seq;
    localparam int AW = 26;
    localparam int DW = 16;
    localparam int CW = 4;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          wr;
        logic          io;
        logic          attr;
        logic          wide;
        logic [DW-1:0] wdata;
        logic          iois16;
        logic [2:0]    wt;
        logic [CW-1:0] s;
        logic [CW-1:0] a;
        logic [CW-1:0] h;
    } vec_t;

    // fields: addr, wr, io, attr, wide, wdata, card 16-bit I/O, wait clocks, setup, active, hold
    localparam vec_t VEC [8] = '{
        '{26'h0001234, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 3'd0, 4'd2, 4'd3, 4'd1},
        '{26'h0000201, 1'b1, 1'b0, 1'b1, 1'b0, 16'hBEEF, 1'b0, 3'd2, 4'd1, 4'd1, 4'd2},
        '{26'h00003F8, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 3'd0, 4'd1, 4'd2, 4'd1},
        '{26'h0000370, 1'b1, 1'b1, 1'b0, 1'b1, 16'hA55A, 1'b0, 3'd1, 4'd2, 4'd1, 4'd1},
        '{26'h0000172, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 3'd0, 4'd1, 4'd1, 4'd1},
        '{26'h0000379, 1'b1, 1'b1, 1'b0, 1'b0, 16'h12C3, 1'b0, 3'd0, 4'd0, 4'd0, 4'd0},
        '{26'h0000010, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 3'd3, 4'd1, 4'd2, 4'd1},
        '{26'h003FFFE, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0F0F, 1'b0, 3'd0, 4'd3, 4'd4, 4'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_write = 1'b0, req_io = 1'b0, req_attr = 1'b0, req_wide = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [CW-1:0] cfg_setup = 4'd1, cfg_active = 4'd1, cfg_hold = 4'd1;
    logic card_wait_n = 1'b1;
    logic card_iois16_n = 1'b1;
    logic [DW-1:0] card_d_in;
    logic [AW-1:0] card_a;
    logic [DW-1:0] card_d_out, rd_data;
    logic card_d_oe, card_oe_n, card_we_n, card_iord_n, card_iowr_n;
    logic card_ce1_n, card_ce2_n, card_reg_n, done, busy;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] card_word(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h96, a[7:0] ^ 8'h3C};
    endfunction

    assign card_d_in = card_word(card_a);

    pccard_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_io(req_io), .req_attr(req_attr), .req_wide(req_wide),
        .req_wdata(req_wdata), .cfg_setup(cfg_setup), .cfg_active(cfg_active),
        .cfg_hold(cfg_hold), .card_wait_n(card_wait_n), .card_iois16_n(card_iois16_n),
        .card_d_in(card_d_in), .card_a(card_a), .card_d_out(card_d_out),
        .card_d_oe(card_d_oe), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
        .card_iord_n(card_iord_n), .card_iowr_n(card_iowr_n), .card_ce1_n(card_ce1_n),
        .card_ce2_n(card_ce2_n), .card_reg_n(card_reg_n), .rd_data(rd_data),
        .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // strobe code: 0 = memory read, 1 = memory write, 2 = I/O read, 3 = I/O write, 7 = none or several
    function automatic logic [2:0] strobe_code();
        logic [3:0] lows;
        lows = {~card_iowr_n, ~card_iord_n, ~card_we_n, ~card_oe_n};
        if ($countones(lows) != 1) return 3'd7;
        if (lows[0]) return 3'd0;
        if (lows[1]) return 3'd1;
        if (lows[2]) return 3'd2;
        return 3'd3;
    endfunction

    function automatic int len1(input logic [CW-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic run_vec(input vec_t v);
        int pieces, act_len, total, cyc, piece, actc, done_at;
        bit narrow, prev;
        logic [2:0] p_code [2];
        int p_act [2];
        logic p_ce1 [2], p_ce2 [2], p_reg [2], p_a0 [2], p_oe [2];
        logic [AW-1:1] p_hi [2];
        logic [DW-1:0] p_dout [2];
        logic [DW-1:0] rd_before, rd_exp, dexp;
        pieces  = (v.io && v.wide && !v.iois16) ? 2 : 1;
        narrow  = !v.wide || (pieces == 2);
        act_len = (len1(v.a) > int'(v.wt) + 1) ? len1(v.a) : int'(v.wt) + 1;
        total   = pieces * (len1(v.s) + act_len + len1(v.h)) + 1;
        rd_before = rd_data;
        for (int i = 0; i < 2; i++) begin
            p_code[i] = 3'd7; p_act[i] = 0; p_ce1[i] = 1'b1; p_ce2[i] = 1'b0;
            p_reg[i] = 1'b1; p_a0[i] = 1'b0; p_oe[i] = 1'b0; p_hi[i] = '0; p_dout[i] = '0;
        end
        req_addr = v.addr; req_write = v.wr; req_io = v.io; req_attr = v.attr;
        req_wide = v.wide; req_wdata = v.wdata; card_iois16_n = !v.iois16;
        cfg_setup = v.s; cfg_active = v.a; cfg_hold = v.h;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; piece = 0; actc = 0; prev = 1'b0; done_at = 0;
        while (done_at == 0 && cyc < 300) begin
            if (strobe_code() != 3'd7) begin
                actc++;
                if (actc == 1 && piece < 2) begin
                    p_code[piece] = strobe_code(); p_ce1[piece] = card_ce1_n;
                    p_ce2[piece] = card_ce2_n; p_reg[piece] = card_reg_n;
                    p_a0[piece] = card_a[0]; p_hi[piece] = card_a[AW-1:1];
                    p_dout[piece] = card_d_out; p_oe[piece] = card_d_oe;
                end
                card_wait_n = !(actc <= int'(v.wt));
                prev = 1'b1;
            end else begin
                if (prev && piece < 2) p_act[piece] = actc;
                if (prev) piece++;
                actc = 0; prev = 1'b0; card_wait_n = 1'b1;
            end
            if (done) done_at = cyc;
            else begin
                @(negedge clk);
                cyc++;
            end
        end
        chk(done_at == total, "R6 done clock", done_at, total);
        chk(piece == pieces, (pieces == 2) ? "R7 piece count" : "R8 piece count", piece, pieces);
        for (int p = 0; p < pieces; p++) begin
            chk(p_code[p] == {1'b0, v.io, v.wr}, "R1 strobe kind", p_code[p], {1'b0, v.io, v.wr});
            chk(p_oe[p] == v.wr, "R1 data drive", p_oe[p], v.wr);
            chk(p_act[p] == act_len, "R5 strobe length", p_act[p], act_len);
            chk(p_ce1[p] == 1'b0, "R3 ce1 low", p_ce1[p], 0);
            chk(p_ce2[p] == narrow, narrow ? "R4 ce2 idle" : "R3 ce2 low", p_ce2[p], narrow);
            chk(p_reg[p] == (v.io ? 1'b0 : !v.attr), "R2 space select", p_reg[p], v.io ? 1'b0 : !v.attr);
            chk(p_hi[p] == v.addr[AW-1:1], "R3 upper address", p_hi[p], v.addr[AW-1:1]);
            chk(p_a0[p] == (!narrow ? 1'b0 : (pieces == 2 ? p[0] : v.addr[0])),
                (pieces == 2) ? "R7 byte order" : "R4 A0", p_a0[p],
                (!narrow ? 1'b0 : (pieces == 2 ? p[0] : v.addr[0])));
            if (v.wr) begin
                if (!narrow) dexp = v.wdata;
                else if (pieces == 2) dexp = {8'h00, (p == 1) ? v.wdata[15:8] : v.wdata[7:0]};
                else dexp = {8'h00, v.wdata[7:0]};
                chk(p_dout[p] == dexp, (pieces == 2) ? "R7 write byte" : "R3 write data", p_dout[p], dexp);
            end
        end
        if (v.wr) rd_exp = rd_before;
        else if (!narrow) rd_exp = card_word({v.addr[AW-1:1], 1'b0});
        else if (pieces == 2) rd_exp = {card_word({v.addr[AW-1:1], 1'b1}) & 16'h00FF, 8'h00}
                                       | (card_word({v.addr[AW-1:1], 1'b0}) & 16'h00FF);
        else rd_exp = {8'h00, card_word(v.addr)[7:0]};
        chk(rd_data == rd_exp, v.wr ? "R9 read data kept" : "R4 R7 R3 read data", rd_data, rd_exp);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one clock", done, 0);
        chk(busy == 1'b0, "R9 idle after done", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({card_oe_n, card_we_n, card_iord_n, card_iowr_n} == 4'hF, "R10 strobes high",
            {card_oe_n, card_we_n, card_iord_n, card_iowr_n}, 4'hF);
        chk({card_ce1_n, card_ce2_n, card_reg_n} == 3'b111, "R10 enables high",
            {card_ce1_n, card_ce2_n, card_reg_n}, 3'b111);
        chk({done, busy, card_d_oe} == 3'b000, "R10 flags low", {done, busy, card_d_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == '0, "R10 read data zero", rd_data, 0);

        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R10 request while busy is ignored
        req_addr = 26'h0000400; req_write = 1'b0; req_io = 1'b0; req_attr = 1'b0;
        req_wide = 1'b1; cfg_setup = 4'd2; cfg_active = 4'd2; cfg_hold = 4'd2;
        card_wait_n = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_io = 1'b1; req_write = 1'b1; req_addr = 26'h0000777; req_valid = 1'b1;
        @(negedge clk);
        chk(strobe_code() == 3'd0, "R10 busy request ignored", strobe_code(), 0);
        chk(card_a == 26'h0000400, "R10 address kept", card_a, 26'h0000400);
        req_valid = 1'b0;
        for (int k = 0; k < 6; k++) @(negedge clk);
        chk(busy == 1'b0, "R10 back to idle", busy, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(card_ce1_n && strobe_code() == 3'd7, "R10 no late start", card_ce1_n, 1);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule